// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

After a system reset, a slave on an I2C bus can be left partway through a byte, holding SDA low and blocking any new transfer. This block runs once the bus controller has been set up: its divider code and own address written, the controller enabled and its interrupt flag cleared. It then works the controller's control levels to force a series of start conditions onto the bus. Each round raises enable, start and transmit together and holds them for one hold delay. It then drops all three for another hold delay. After nine rounds the controller is left enabled and idle, and a done flag is raised.

The hold delay comes from the 6-bit frequency-divider code, using the same SCL and SDA tap tables that set the bus timing. The delay is counted in units. The parameter `UNIT_CYCLES` sets how many system clock cycles make one unit, so the block can be matched to the real clock, or the unit can be made short for simulation. A single-cycle `launch` pulse starts the sequence. The block reads `div_code` at that instant and ignores it for the rest of the sequence.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, and until the first accepted launch, `ctl_en`, `ctl_sta`, `ctl_tx` and `done` are all 0.
- R2: When `launch` is sampled high while the block is idle or finished, `ctl_en`, `ctl_sta` and `ctl_tx` are all 1 from the very next clock cycle.
- R3: Each drive phase (all three controls at 1) lasts exactly D × UNIT_CYCLES cycles. D = B + (T − 1) × S + 3. B and S are chosen by `div_code[4:2]` = j: B = 4,4,6,6,14,30,62,126 and S = 1,2,4,8,16,32,64,128 for j = 0..7.
- R4: T is chosen by the 3-bit index {`div_code[5]`, `div_code[1]`, `div_code[0]`} = i: T = 3,3,4,4,1,1,2,2 for i = 0..7.
- R5: Each drive phase is followed at once by a quiet phase of D × UNIT_CYCLES cycles, during which all three controls are 0 and `done` is 0.
- R6: Exactly 9 drive/quiet rounds run, one straight after another.
- R7: After the ninth quiet phase, `ctl_en` = 1, `ctl_sta` = `ctl_tx` = 0 and `done` = 1. These values hold until the next accepted launch.
- R8: While a sequence is running, `launch` pulses and changes on `div_code` have no effect. The phase lengths stay those of the code that was read at launch.
- R9: A launch accepted after `done` is set clears `done` and starts a new sequence timed from the new code.
- R10: The phase length scales linearly with the parameter `UNIT_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| launch | input | 1 | Single-cycle pulse that starts the recovery sequence |
| div_code | input | 6 | Frequency-divider code of the controller, read at launch |
| ctl_en | output | 1 | Controller enable level |
| ctl_sta | output | 1 | Controller start (master mode) level |
| ctl_tx | output | 1 | Controller transmit-direction level |
| done | output | 1 | High once the final enable-only state is reached |

## Verification
All 64 divider codes are run one after another with a one-cycle unit, and every drive and quiet phase is measured against the delay the bench computes. Because the codes share table entries, this separates a wrong SCL pair from a wrong SDA tap index, and a wrong order of the bits in that index. Running the sequences back to back with no reset checks that a new launch after `done` starts a fresh run. A separate run sends a launch pulse and a different code partway through a phase, and the phase lengths must not change. A second instance with a three-cycle unit repeats a long code and a short code, which shows the unit really scales the phases and is not simply added.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_QUIET = 2'd2,
    ST_HOLD  = 2'd3
  } rcv_state_t;

  localparam int unsigned UNITS_W   = 10;
  localparam int unsigned UNITS_MIN = 7;
  localparam int unsigned UNITS_MAX = 513;

  function automatic logic [7:0] scl_base(input logic [2:0] j);
    case (j)
      3'd0:    scl_base = 8'd4;
      3'd1:    scl_base = 8'd4;
      3'd2:    scl_base = 8'd6;
      3'd3:    scl_base = 8'd6;
      3'd4:    scl_base = 8'd14;
      3'd5:    scl_base = 8'd30;
      3'd6:    scl_base = 8'd62;
      default: scl_base = 8'd126;
    endcase
  endfunction

  function automatic logic [7:0] scl_step(input logic [2:0] j);
    scl_step = 8'd1 << j;
  endfunction

  function automatic logic [2:0] sda_taps(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: sda_taps = 3'd3;
      3'd2, 3'd3: sda_taps = 3'd4;
      3'd4, 3'd5: sda_taps = 3'd1;
      default:    sda_taps = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/rcv_rst_sync.sv
module rcv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/rcv_hold_calc.sv
module rcv_hold_calc
  import rcv_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 100,
  parameter int unsigned LEN_W       = 16
) (
  input  logic [5:0]       div_code,
  output logic [LEN_W-1:0] phase_len
);
  logic [2:0]         pair_idx;
  logic [2:0]         sda_idx;
  logic [UNITS_W-1:0] base_u;
  logic [UNITS_W-1:0] step_u;
  logic [UNITS_W-1:0] tap_m1;
  logic [UNITS_W-1:0] units;

  always_comb begin
    pair_idx  = div_code[4:2];
    sda_idx   = {div_code[5], div_code[1], div_code[0]};
    base_u    = UNITS_W'(scl_base(pair_idx));
    step_u    = UNITS_W'(scl_step(pair_idx));
    tap_m1    = UNITS_W'(sda_taps(sda_idx)) - UNITS_W'(1);
    units     = base_u + tap_m1 * step_u + UNITS_W'(3);
    phase_len = LEN_W'(units) * LEN_W'(UNIT_CYCLES);
  end
endmodule

// File: rtl/rcv_phase_timer.sv
module rcv_phase_timer #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             run,
  output logic [LEN_W-1:0] count,
  output logic             expire
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load)        cnt_d = load_len - LEN_W'(1);
    else if (cnt_en) cnt_d = cnt_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign expire = run && (cnt_q == '0);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q == '0) |=> (cnt_q == '0 || $past(load)));
endmodule

// File: rtl/rcv_seq_fsm.sv
module rcv_seq_fsm
  import rcv_pkg::*;
#(
  parameter int unsigned ITERS       = 9,
  parameter int unsigned UNIT_CYCLES = 100,
  parameter int unsigned LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LEN_W-1:0] new_len,
  input  logic             expire,
  input  logic [LEN_W-1:0] count,
  output logic             tmr_load,
  output logic [LEN_W-1:0] tmr_len,
  output logic             tmr_run,
  output rcv_state_t       state
);
  localparam int unsigned ITER_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(ITERS - 1);

  rcv_state_t       st_q, st_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              accept;
  logic              st_en, iter_en, len_en;

  always_comb begin
    st_d     = st_q;
    iter_d   = iter_q;
    len_d    = len_q;
    tmr_load = 1'b0;
    tmr_len  = len_q;
    accept   = 1'b0;
    case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (launch) begin
          accept   = 1'b1;
          st_d     = ST_DRIVE;
          iter_d   = '0;
          len_d    = new_len;
          tmr_load = 1'b1;
          tmr_len  = new_len;
        end
      end
      ST_DRIVE: begin
        if (expire) begin
          st_d     = ST_QUIET;
          tmr_load = 1'b1;
        end
      end
      ST_QUIET: begin
        if (expire) begin
          if (iter_q == LAST_ITER) begin
            st_d = ST_HOLD;
          end else begin
            st_d     = ST_DRIVE;
            iter_d   = iter_q + ITER_W'(1);
            tmr_load = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    st_en   = (st_d != st_q);
    iter_en = (iter_d != iter_q);
    len_en  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
      len_q  <= '0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (iter_en) iter_q <= iter_d;
      if (len_en)  len_q  <= len_d;
    end
  end

  assign tmr_run = (st_q == ST_DRIVE) || (st_q == ST_QUIET);
  assign state   = st_q;

  assert_iter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= LAST_ITER);

  assert_count_in_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> (count < len_q));

  assert_len_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> (len_q >= LEN_W'(UNITS_MIN * UNIT_CYCLES)));

  assert_drive_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRIVE && !expire) |=> (st_q == ST_DRIVE && $stable(len_q)));

  assert_quiet_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRIVE && expire) |=> (st_q == ST_QUIET));
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import rcv_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 100,
  parameter int unsigned ITERS       = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [5:0] div_code,
  output logic       ctl_en,
  output logic       ctl_sta,
  output logic       ctl_tx,
  output logic       done
);
  localparam int unsigned LEN_W = $clog2(UNITS_MAX * UNIT_CYCLES + 1);

  logic             rst_s_n;
  logic [LEN_W-1:0] new_len;
  logic [LEN_W-1:0] tmr_len;
  logic [LEN_W-1:0] tmr_count;
  logic             tmr_load;
  logic             tmr_run;
  logic             tmr_expire;
  rcv_state_t       state;

  rcv_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  rcv_hold_calc #(.UNIT_CYCLES(UNIT_CYCLES), .LEN_W(LEN_W)) u_calc (
    .div_code  (div_code),
    .phase_len (new_len)
  );

  rcv_phase_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .run      (tmr_run),
    .count    (tmr_count),
    .expire   (tmr_expire)
  );

  rcv_seq_fsm #(.ITERS(ITERS), .UNIT_CYCLES(UNIT_CYCLES), .LEN_W(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .launch   (launch),
    .new_len  (new_len),
    .expire   (tmr_expire),
    .count    (tmr_count),
    .tmr_load (tmr_load),
    .tmr_len  (tmr_len),
    .tmr_run  (tmr_run),
    .state    (state)
  );

  always_comb begin
    ctl_en  = (state == ST_DRIVE) || (state == ST_HOLD);
    ctl_sta = (state == ST_DRIVE);
    ctl_tx  = (state == ST_DRIVE);
    done    = (state == ST_HOLD);
  end

  assert_sta_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctl_sta |-> ctl_en);

  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && !launch) |=> (done && ctl_en && !ctl_sta && !ctl_tx));

  assert_rerun_clears_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(done) |-> ($past(launch) && ctl_sta));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ctl_en) |-> (!ctl_sta && !ctl_tx && !done));
endmodule

// File: tb/i2c_bus_unstick_tb_top.sv
module i2c_bus_unstick_tb_top;
  localparam int unsigned WATCHDOG = 190000;

  logic clk;
  logic rst_n;
  logic launch_a, launch_b;
  logic [5:0] code_a, code_b;
  logic a_en, a_sta, a_tx, a_done;
  logic b_en, b_sta, b_tx, b_done;
  logic use_b;
  logic o_en, o_sta, o_tx, o_done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  i2c_bus_unstick #(.UNIT_CYCLES(1), .ITERS(9)) dut_i (
    .clk (clk), .rst_n (rst_n), .launch (launch_a), .div_code (code_a),
    .ctl_en (a_en), .ctl_sta (a_sta), .ctl_tx (a_tx), .done (a_done)
  );

  i2c_bus_unstick #(.UNIT_CYCLES(3), .ITERS(9)) dut_u3_i (
    .clk (clk), .rst_n (rst_n), .launch (launch_b), .div_code (code_b),
    .ctl_en (b_en), .ctl_sta (b_sta), .ctl_tx (b_tx), .done (b_done)
  );

  assign o_en   = use_b ? b_en   : a_en;
  assign o_sta  = use_b ? b_sta  : a_sta;
  assign o_tx   = use_b ? b_tx   : a_tx;
  assign o_done = use_b ? b_done : a_done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog R6: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_units(input int c);
    int j = (c >> 2) & 7;
    int i = ((c >> 3) & 4) | (c & 3);
    int base = (j < 2) ? 4 : ((j == 2) ? 6 : (1 << j) - 2);
    int step = 1 << j;
    int sda  = (i < 4) ? 3 + (i >> 1) : 1 + ((i >> 1) & 1);
    return base + (sda - 1) * step + 3;
  endfunction

  function automatic int pat();
    return {o_done, o_en, o_sta, o_tx};
  endfunction

  task automatic pulse(input bit on_b, input logic [5:0] c);
    @(negedge clk);
    if (on_b) begin code_b = c; launch_b = 1'b1; end
    else      begin code_a = c; launch_a = 1'b1; end
    @(negedge clk);
    launch_a = 1'b0;
    launch_b = 1'b0;
  endtask

  task automatic watch(input int exp_len);
    int rounds = 0;
    for (int guard = 0; guard < 12; guard++) begin
      int a = 0;
      int r = 0;
      if (pat() != 4'b0111) break;
      while (pat() == 4'b0111 && a < 4000) begin a++; @(negedge clk); end
      chk(a == exp_len, "R3 R4 drive length", a, exp_len);
      while (pat() == 4'b0000 && r < 4000) begin r++; @(negedge clk); end
      chk(r == exp_len, "R5 quiet length", r, exp_len);
      rounds++;
    end
    chk(rounds == 9, "R6 round count", rounds, 9);
    chk(pat() == 4'b1100, "R7 final state", pat(), 4'b1100);
    repeat (6) @(negedge clk);
    chk(pat() == 4'b1100, "R7 final state held", pat(), 4'b1100);
  endtask

  task automatic run(input bit on_b, input int c, input int unit, input bit disturb);
    int exp_len = exp_units(c) * unit;
    use_b = on_b;
    pulse(on_b, 6'(c));
    chk(pat() == 4'b0111, "R2 R9 launch response", pat(), 4'b0111);
    fork
      watch(exp_len);
      begin
        if (disturb) begin
          repeat (3) @(negedge clk);
          code_a   = 6'(c) ^ 6'h3F;
          launch_a = 1'b1;
          @(negedge clk);
          launch_a = 1'b0;
        end
      end
    join
  endtask

  initial begin
    rst_n = 1'b0; launch_a = 1'b0; launch_b = 1'b0;
    code_a = '0; code_b = '0; use_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({a_done, a_en, a_sta, a_tx} == 4'b0000, "R1 reset outputs", {a_done, a_en, a_sta, a_tx}, 0);
    chk({b_done, b_en, b_sta, b_tx} == 4'b0000, "R1 reset outputs u3", {b_done, b_en, b_sta, b_tx}, 0);
    code_a = 6'h3F;
    repeat (5) @(negedge clk);
    chk({a_done, a_en, a_sta, a_tx} == 4'b0000, "R1 idle without launch", {a_done, a_en, a_sta, a_tx}, 0);

    for (int c = 0; c < 64; c++) run(1'b0, c, 1, 1'b0);

    // R8: launch and new code during a drive phase
    run(1'b0, 0, 1, 1'b1);
    run(1'b0, 6'h21, 1, 1'b1);

    // R10: three-cycle unit
    run(1'b1, 6'h3F, 3, 1'b0);
    run(1'b1, 6'h05, 3, 1'b0);

    summary();
    $finish;
  end
endmodule